// File: doc/BRIEF.md
# Crossing Signal Sequencer with Pedestrian Pre-emption

This block drives the single vehicle signal at a pedestrian crossing. It steps through four phases: red, green, yellow and walk. On every phase entry a down-counter is loaded with that phase's duration in seconds. The counter decrements on each one-second tick, and the controller moves on once the counter reads zero. A press of the crossing button is held in a sticky request flag. While green is showing, that flag ends green at once and starts a walk phase. Green does not run out its time first.

The lamp outputs are Moore outputs: they follow from the current phase alone. The current phase and the remaining seconds are also brought out. The seconds tick comes from an internal clock prescaler by default. A parameter lets an external tick pin drive the counter instead, so simulations can run at any pace.

States and transitions: RED goes to GREEN on expiry, and this transition clears the request (red_expire). GREEN goes to WALK when a request is pending, whatever the count (green_preempt). GREEN goes to YELLOW on expiry with no request (green_expire). WALK goes to YELLOW on expiry (walk_expire). YELLOW goes to RED on expiry (yellow_expire). Every phase stays where it is and counts down on ticks while its count is nonzero (hold).

Top module: `ped_signal_ctrl`

## Requirements
- R1: While `rst` is sampled high, the next state is RED with `remain` = T_RED, `walk_on` low and the request flag clear.
- R2: `phase` encodes 0 = RED, 1 = GREEN, 2 = YELLOW, 3 = WALK. `lamp_red` is high in RED and WALK, `lamp_yellow` only in YELLOW, `lamp_green` only in GREEN. `walk_on` is high only in WALK. Exactly one lamp is lit at all times.
- R3: In any phase with `remain` nonzero and no pre-emption, `remain` drops by one on a cycle with a tick. On a cycle without a tick it holds. The phase does not change.
- R4: In RED with `remain` = 0, the next cycle is GREEN with `remain` = T_GREEN, and the request flag is cleared.
- R5: In GREEN with the request pending, the next cycle is WALK with `remain` = T_WALK. This happens even when `remain` is zero in the same cycle.
- R6: In GREEN with `remain` = 0 and no request, the next cycle is YELLOW with `remain` = T_YELLOW.
- R7: In WALK, the button has no effect on phase or count. With `remain` = 0 the next cycle is YELLOW with `remain` = T_YELLOW.
- R8: In YELLOW, the button has no effect on phase or count. With `remain` = 0 the next cycle is RED with `remain` = T_RED.
- R9: A button press in any phase sets the request flag from the next cycle on. RED leaves only on expiry, whatever the button does.
- R10: A press in the same cycle as the RED-to-GREEN transition is dropped. Clearing wins, so that green runs its full time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ext | input | 1 | External seconds tick, used when USE_EXT_TICK = 1 |
| button | input | 1 | Crossing button pulse |
| lamp_red | output | 1 | Vehicle red lamp |
| lamp_yellow | output | 1 | Vehicle yellow lamp |
| lamp_green | output | 1 | Vehicle green lamp |
| walk_on | output | 1 | Pedestrian walk indication |
| phase | output | 2 | Current phase code |
| remain | output | CW | Seconds left in the current phase |

## Verification
The bench builds the block with USE_EXT_TICK = 1 and shrinks the durations to green 6, yellow 2, walk 4 and red 5. A full cycle of phases then takes a few dozen clocks, so every transition can be reached many times. The bench steers the tick pin directly, which brings tick gaps, presses landing on the exact expiry cycle and a press coinciding with the red-to-green clear within easy reach. A random stretch with sparse ticks and presses then follows, and a reference model is compared on every cycle.

// File: rtl/ped_pkg.sv
package ped_pkg;
    typedef enum logic [1:0] {
        PH_RED    = 2'd0,
        PH_GREEN  = 2'd1,
        PH_YELLOW = 2'd2,
        PH_WALK   = 2'd3
    } phase_e;
endpackage

// File: rtl/ped_tick_gen.sv
module ped_tick_gen #(
    parameter int PRESCALE = 200_000_000,
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/ped_req_latch.sv
module ped_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic press,
    input  logic clr,
    output logic req
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else if (clr)
            req_q <= 1'b0;
        else if (press)
            req_q <= 1'b1;
    end

    assign req = req_q;

    assert_press_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (press && !clr) |=> req);

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> !req);
endmodule

// File: rtl/ped_phase_fsm.sv
module ped_phase_fsm
    import ped_pkg::*;
#(
    parameter int T_GREEN  = 30,
    parameter int T_YELLOW = 5,
    parameter int T_WALK   = 15,
    parameter int T_RED    = 30,
    parameter int CW       = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          req,
    output phase_e        phase,
    output logic [CW-1:0] remain,
    output logic          clr_req
);
    localparam logic [CW-1:0] LD_GREEN  = CW'(T_GREEN);
    localparam logic [CW-1:0] LD_YELLOW = CW'(T_YELLOW);
    localparam logic [CW-1:0] LD_WALK   = CW'(T_WALK);
    localparam logic [CW-1:0] LD_RED    = CW'(T_RED);

    phase_e        phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cnt_run;
    logic          zero;

    assign zero    = (cnt_q == '0);
    assign cnt_run = tick ? cnt_q - 1'b1 : cnt_q;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_run;
        clr_req = 1'b0;
        unique case (phase_q)
            PH_RED: begin
                if (zero) begin
                    phase_d = PH_GREEN;
                    cnt_d   = LD_GREEN;
                    clr_req = 1'b1;
                end
            end
            PH_GREEN: begin
                if (req) begin
                    phase_d = PH_WALK;
                    cnt_d   = LD_WALK;
                end else if (zero) begin
                    phase_d = PH_YELLOW;
                    cnt_d   = LD_YELLOW;
                end
            end
            PH_WALK: begin
                if (zero) begin
                    phase_d = PH_YELLOW;
                    cnt_d   = LD_YELLOW;
                end
            end
            PH_YELLOW: begin
                if (zero) begin
                    phase_d = PH_RED;
                    cnt_d   = LD_RED;
                end
            end
            default: begin
                phase_d = PH_RED;
                cnt_d   = LD_RED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RED;
            cnt_q   <= LD_RED;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign phase  = phase_q;
    assign remain = cnt_q;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (phase_q == PH_RED && cnt_q == LD_RED));

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!zero && !tick && !(phase_q == PH_GREEN && req)) |=> ($stable(cnt_q) && $stable(phase_q)));

    assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
        (!zero && tick && !(phase_q == PH_GREEN && req)) |=> (cnt_q == $past(cnt_q) - 1'b1 && $stable(phase_q)));

    assert_red_expire_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RED && zero) |=> (phase_q == PH_GREEN && cnt_q == LD_GREEN));

    assert_green_preempt_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GREEN && req) |=> (phase_q == PH_WALK && cnt_q == LD_WALK));

    assert_green_expire_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GREEN && !req && zero) |=> (phase_q == PH_YELLOW && cnt_q == LD_YELLOW));

    assert_walk_expire_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WALK && zero) |=> (phase_q == PH_YELLOW && cnt_q == LD_YELLOW));

    assert_yellow_expire_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_YELLOW && zero) |=> (phase_q == PH_RED && cnt_q == LD_RED));
endmodule

// File: rtl/ped_signal_ctrl.sv
module ped_signal_ctrl
    import ped_pkg::*;
#(
    parameter int T_GREEN      = 30,
    parameter int T_YELLOW     = 5,
    parameter int T_WALK       = 15,
    parameter int T_RED        = 30,
    parameter int PRESCALE     = 200_000_000,
    parameter bit USE_EXT_TICK = 1'b0,
    localparam int TMAX_A = (T_GREEN > T_YELLOW) ? T_GREEN : T_YELLOW,
    localparam int TMAX_B = (T_WALK > T_RED) ? T_WALK : T_RED,
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B,
    localparam int CW     = $clog2(TMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_ext,
    input  logic          button,
    output logic          lamp_red,
    output logic          lamp_yellow,
    output logic          lamp_green,
    output logic          walk_on,
    output logic [1:0]    phase,
    output logic [CW-1:0] remain
);
    logic   tick_int;
    logic   tick;
    logic   req;
    logic   clr_req;
    phase_e cur_phase;

    generate
        if (USE_EXT_TICK) begin : g_ext_tick
            assign tick_int = 1'b0;
        end else begin : g_int_tick
            ped_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
                .clk  (clk),
                .rst  (rst),
                .tick (tick_int)
            );
        end
    endgenerate

    assign tick = USE_EXT_TICK ? tick_ext : tick_int;

    ped_req_latch u_req (
        .clk   (clk),
        .rst   (rst),
        .press (button),
        .clr   (clr_req),
        .req   (req)
    );

    ped_phase_fsm #(
        .T_GREEN  (T_GREEN),
        .T_YELLOW (T_YELLOW),
        .T_WALK   (T_WALK),
        .T_RED    (T_RED),
        .CW       (CW)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .req     (req),
        .phase   (cur_phase),
        .remain  (remain),
        .clr_req (clr_req)
    );

    always_comb begin
        lamp_red    = 1'b0;
        lamp_yellow = 1'b0;
        lamp_green  = 1'b0;
        walk_on     = 1'b0;
        unique case (cur_phase)
            PH_RED:    lamp_red = 1'b1;
            PH_GREEN:  lamp_green = 1'b1;
            PH_YELLOW: lamp_yellow = 1'b1;
            PH_WALK: begin
                lamp_red = 1'b1;
                walk_on  = 1'b1;
            end
            default:   lamp_red = 1'b1;
        endcase
    end

    assign phase = cur_phase;

    assert_one_lamp_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot({lamp_red, lamp_yellow, lamp_green}));

    assert_walk_only_in_walk_R2: assert property (@(posedge clk) disable iff (rst)
        walk_on |-> (cur_phase == PH_WALK && !lamp_green && !lamp_yellow));
endmodule

// File: tb/ped_signal_ctrl_test.sv
module ped_signal_ctrl_test;
    localparam int TG = 6;
    localparam int TY = 2;
    localparam int TW = 4;
    localparam int TR = 5;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_ext = 1'b0;
    logic button = 1'b0;
    logic lamp_red, lamp_yellow, lamp_green, walk_on;
    logic [1:0] phase;
    logic [CW-1:0] remain;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    int m_ph = 0;
    int m_cnt = TR;
    bit m_req = 1'b0;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    ped_signal_ctrl #(
        .T_GREEN(TG), .T_YELLOW(TY), .T_WALK(TW), .T_RED(TR),
        .PRESCALE(2), .USE_EXT_TICK(1'b1)
    ) uut (
        .clk(clk), .rst(rst), .tick_ext(tick_ext), .button(button),
        .lamp_red(lamp_red), .lamp_yellow(lamp_yellow), .lamp_green(lamp_green),
        .walk_on(walk_on), .phase(phase), .remain(remain)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // reference model: phases 0 red, 1 green, 2 yellow, 3 walk
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ph = 0; m_cnt = TR; m_req = 1'b0; m_tag = "R1";
        end else begin
            bit clr;
            clr = 1'b0;
            m_tag = "R3";
            if (m_ph == 0 && m_cnt == 0) begin
                m_ph = 1; m_cnt = TG; clr = 1'b1; m_tag = "R4";
            end else if (m_ph == 1 && m_req) begin
                m_ph = 3; m_cnt = TW; m_tag = "R5";
            end else if (m_ph == 1 && m_cnt == 0) begin
                m_ph = 2; m_cnt = TY; m_tag = "R6";
            end else if (m_ph == 3 && m_cnt == 0) begin
                m_ph = 2; m_cnt = TY; m_tag = "R7";
            end else if (m_ph == 2 && m_cnt == 0) begin
                m_ph = 0; m_cnt = TR; m_tag = "R8";
            end else if (tick_ext) begin
                m_cnt = m_cnt - 1;
            end
            if (clr) m_req = 1'b0;
            else if (button) m_req = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(m_tag, phase, m_ph, "phase");
            chk(m_tag, remain, m_cnt, "remain");
            chk("R2", lamp_red, (m_ph == 0 || m_ph == 3), "lamp_red");
            chk("R2", lamp_yellow, (m_ph == 2), "lamp_yellow");
            chk("R2", lamp_green, (m_ph == 1), "lamp_green");
            chk("R2", walk_on, (m_ph == 3), "walk_on");
        end
    end

    task automatic run_to(input int p);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (phase == 2'(p)) break;
            tick_ext = 1'b1;
            button = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", phase, 0, "reset phase");
        chk("R1", remain, TR, "reset remain");
        chk("R1", walk_on, 0, "reset walk");
        chk("R1", lamp_red, 1, "reset lamp_red");
        rst = 1'b0;
        tick_ext = 1'b1;

        run_to(1);
        chk("R4", remain, TG, "green load");
        chk("R2", lamp_green, 1, "green lamp");
        tick_ext = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3", remain, TG, "hold without tick");
        end
        tick_ext = 1'b1; button = 1'b1;
        @(negedge clk);
        button = 1'b0;
        chk("R9", phase, 1, "press registered, still green");
        chk("R3", remain, TG - 1, "count after tick");
        @(negedge clk);
        chk("R5", phase, 3, "pre-empt to walk");
        chk("R5", remain, TW, "walk load");
        chk("R2", walk_on, 1, "walk shown");
        button = 1'b1;
        @(negedge clk);
        button = 1'b0;
        chk("R7", phase, 3, "walk ignores button");
        chk("R7", remain, TW - 1, "walk counts on");
        run_to(2);
        chk("R7", remain, TY, "yellow after walk");
        button = 1'b1;
        @(negedge clk);
        button = 1'b0;
        chk("R8", phase, 2, "yellow ignores button");
        chk("R8", remain, TY - 1, "yellow counts on");
        run_to(0);
        chk("R8", remain, TR, "red load");
        tick_ext = 1'b0; button = 1'b1;
        @(negedge clk);
        button = 1'b0;
        chk("R9", phase, 0, "red stays with press");
        run_to(1);
        tick_ext = 1'b0;
        @(negedge clk);
        chk("R4", phase, 1, "request cleared on entering green");

        // R10: press on the red-to-green cycle is dropped
        run_to(0);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (phase == 2'd0 && remain == '0) break;
            tick_ext = 1'b1; button = 1'b0;
        end
        button = 1'b1; tick_ext = 1'b0;
        @(negedge clk);
        button = 1'b0;
        chk("R10", phase, 1, "entered green");
        @(negedge clk);
        chk("R10", phase, 1, "same-cycle press dropped");
        run_to(2);
        chk("R6", remain, TY, "green expiry to yellow");

        // R5 priority over expiry
        run_to(1);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (remain == 3'd1) break;
            tick_ext = 1'b1; button = 1'b0;
        end
        tick_ext = 1'b1; button = 1'b1;
        @(negedge clk);
        button = 1'b0;
        chk("R5", remain, 0, "green at zero with request");
        @(negedge clk);
        chk("R5", phase, 3, "request beats expiry");

        // random stretch
        begin
            int lf;
            lf = 32'h1ace;
            for (int i = 0; i < 4000; i++) begin
                @(negedge clk);
                lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
                tick_ext = lf[0] & lf[3];
                button = (lf[7:4] == 4'hA);
            end
        end
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule